// File: doc/BRIEF.md
# UDP Image Row Packet Framer

The framer turns a stream of 16-bit pixel words into complete Ethernet/IPv4/UDP frames, one frame per image row slice. It writes every frame word by word into the transmit buffer of an external MAC through a 16-bit write port that takes an address. Each frame has three parts. First come 21 constant header words. Next comes a one-word row tag. Last come `PAY_WORDS` payload words taken from the pixel FIFO. When the last payload word has been accepted, the block pulses a transmit-start strobe. It then waits for the MAC to report completion.

All header constants are byte-swapped for a little-endian 16-bit bus, so the low byte of each bus word is the first byte on the wire. The IPv4 and UDP checksum words are left at zero because the MAC fills them in. Each datagram carries the row index ahead of its pixels. The receiver can therefore place each row in its own slot, and a lost packet costs only that row.

Both streaming edges use valid/ready. A pixel word moves when `pix_valid` and `pix_ready` are both high at a clock edge. Once the source raises `pix_valid`, it must keep `pix_data` stable until the word is taken. A MAC write happens when `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the block holds `wr_valid`, `wr_addr` and `wr_data`. During the payload, `pix_ready` follows `wr_ready`, so any stall in the MAC passes straight back to the pixel FIFO.

Top module: `udp_row_framer`

## Requirements
- R1: While reset is held, `wr_valid`, `pix_ready` and `tx_start` are all low.
- R2: A frame starts only at a clock edge where `net_idle` is high and `fifo_level` is at least `PAY_WORDS`. With either condition missing, no write is issued.
- R3: Addresses 0 to 20 carry these words, in address order:
  - 0 to 2: FFFF, FFFF, FFFF
  - 3 to 5: 1111, 1111, 1111
  - 6 to 8: 0008, 0045, 1E04
  - 9 to 12: 0000, 0000, 1140, 0000
  - 13 to 16: A8C0, CC01, FFFF, FFFF
  - 17 to 20: 7017, 7017, 0A04, 0000
- R4: Address 21 carries the row index, zero-extended, with the low byte of the index in bits 7:0. The row index of the first frame after reset is 0.
- R5: Addresses 22 to 21+`PAY_WORDS` carry the pixel words in arrival order. A frame has exactly 22+`PAY_WORDS` writes at consecutive addresses, and every payload write coincides with one pixel handshake.
- R6: While `wr_ready` is low, no pixel is consumed, and a pending write keeps its address and data. When `pix_valid` drops during the payload, the frame pauses and the address does not skip.
- R7: `tx_start` is high for exactly one cycle, in the cycle after the last payload write is accepted. No write happens between `tx_start` and the next `tx_done`.
- R8: The row index increases by one at each `tx_done`. After `ROWS`-1 it wraps to 0.
- R9: `img_restart` sets the row index to 0. If it arrives in the same cycle as `tx_done`, the restart wins and the next frame carries row 0.
- R10: `pix_ready` stays low during the header words (addresses 0 to 21).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| net_idle | input | 1 | Network side can take a new frame |
| img_restart | input | 1 | Start of a new image; clears the row index |
| fifo_level | input | CNT_W | Words currently held in the pixel FIFO |
| pix_valid | input | 1 | Pixel word available |
| pix_ready | output | 1 | Pixel word taken this cycle when valid |
| pix_data | input | 16 | Pixel word, first wire byte in bits 7:0 |
| wr_valid | output | 1 | Write to the MAC buffer pending |
| wr_ready | input | 1 | MAC accepts the write |
| wr_addr | output | ADDR_W | Word index inside the frame |
| wr_data | output | 16 | Word to write |
| tx_start | output | 1 | One-cycle strobe that launches the frame |
| tx_done | input | 1 | MAC finished sending the frame |

## Verification
Frames are produced under four delivery patterns:
- Both sides are always ready. This baseline shows the header table and payload order.
- The pixel source has periodic gaps. This separates a design that pauses cleanly from one that skips addresses or writes stale data.
- The MAC periodically refuses writes. This shows whether stalls are held and passed back to the pixel FIFO.
- Both kinds of stall happen together.

The start gate is tried with the network busy and with the FIFO holding one word less than a payload, and one frame starts at exactly a full payload. The row tag is followed through a full wrap, through a restart while idle, and through a restart in the same cycle as `tx_done`, where a priority error would show up as row 1 instead of row 0.

// File: rtl/urf_pkg.sv
`timescale 1ns/1ps
package urf_pkg;
  localparam int HDR_WORDS = 22;
  localparam int HSEL_W    = $clog2(HDR_WORDS);
  localparam int WORD_W    = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_KICK,
    ST_WAIT
  } urf_state_e;

  // Byte order on the bus: the low byte goes out first.
  function automatic logic [WORD_W-1:0] bswap16(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/urf_hdr_gen.sv
`timescale 1ns/1ps
module urf_hdr_gen import urf_pkg::*; #(
  parameter int          PAY_WORDS = 512,
  parameter logic [47:0] SRC_MAC   = 48'h1111_1111_1111,
  parameter logic [47:0] DST_MAC   = 48'hFFFF_FFFF_FFFF,
  parameter logic [31:0] SRC_IP    = 32'hC0A8_01CC,
  parameter logic [31:0] DST_IP    = 32'hFFFF_FFFF,
  parameter logic [15:0] SRC_PORT  = 16'd6000,
  parameter logic [15:0] DST_PORT  = 16'd6000,
  parameter logic [7:0]  TTL       = 8'h40
) (
  input  logic [HSEL_W-1:0] sel,
  input  logic [WORD_W-1:0] row_tag,
  output logic [WORD_W-1:0] word
);
  localparam int TBL_N   = 1 << HSEL_W;
  localparam int UDP_LEN = 8 + 2 + 2 * PAY_WORDS;
  localparam int IP_LEN  = 20 + UDP_LEN;
  localparam logic [15:0] ETH_IPV4  = 16'h0800;
  localparam logic [15:0] VER_IHL   = 16'h4500;
  localparam logic [7:0]  PROTO_UDP = 8'h11;

  logic [WORD_W-1:0] tbl [TBL_N];

  // Address fields: three words each, most significant word first.
  for (genvar g = 0; g < 3; g++) begin : g_mac
    assign tbl[g]     = bswap16(DST_MAC[47-16*g -: 16]);
    assign tbl[3 + g] = bswap16(SRC_MAC[47-16*g -: 16]);
  end

  for (genvar g = 0; g < 2; g++) begin : g_ip
    assign tbl[13 + g] = bswap16(SRC_IP[31-16*g -: 16]);
    assign tbl[15 + g] = bswap16(DST_IP[31-16*g -: 16]);
  end

  assign tbl[6]  = bswap16(ETH_IPV4);
  assign tbl[7]  = bswap16(VER_IHL);
  assign tbl[8]  = bswap16(16'(IP_LEN));
  assign tbl[9]  = '0;                      // identification
  assign tbl[10] = '0;                      // flags and fragment offset
  assign tbl[11] = bswap16({TTL, PROTO_UDP});
  assign tbl[12] = '0;                      // IPv4 checksum, MAC fills it
  assign tbl[17] = bswap16(SRC_PORT);
  assign tbl[18] = bswap16(DST_PORT);
  assign tbl[19] = bswap16(16'(UDP_LEN));
  assign tbl[20] = '0;                      // UDP checksum, MAC fills it
  assign tbl[21] = row_tag;                 // already little-endian

  for (genvar g = HDR_WORDS; g < TBL_N; g++) begin : g_pad
    assign tbl[g] = '0;
  end

  assign word = tbl[sel];
endmodule

// File: rtl/urf_row_ctr.sv
`timescale 1ns/1ps
module urf_row_ctr #(
  parameter  int ROWS = 1536,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          restart,
  output logic [RW-1:0] row
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
    end else if (restart) begin
      row <= '0;
    end else if (advance) begin
      row <= (row == LAST_ROW) ? '0 : row + 1'b1;
    end
  end
endmodule

// File: rtl/urf_seq.sv
`timescale 1ns/1ps
module urf_seq import urf_pkg::*; #(
  parameter  int PAY_WORDS = 512,
  parameter  int CNT_W     = 12,
  localparam int ADDR_W    = $clog2(HDR_WORDS + PAY_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_idle,
  input  logic [CNT_W-1:0]  fifo_level,
  input  logic              pix_valid,
  input  logic              wr_ready,
  input  logic              tx_done,
  output urf_state_e        state,
  output logic [ADDR_W-1:0] idx,
  output logic              frame_go,
  output logic              row_adv
);
  localparam logic [ADDR_W-1:0] HDR_END  = ADDR_W'(HDR_WORDS - 1);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(HDR_WORDS + PAY_WORDS - 1);
  localparam logic [CNT_W-1:0]  NEED     = CNT_W'(PAY_WORDS);

  assign frame_go = (state == ST_IDLE) && net_idle && (fifo_level >= NEED);
  assign row_adv  = (state == ST_WAIT) && tx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          idx <= '0;
          if (frame_go) state <= ST_HDR;
        end
        ST_HDR: begin
          if (wr_ready) begin
            idx <= idx + 1'b1;
            if (idx == HDR_END) state <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (pix_valid && wr_ready) begin
            if (idx == LAST_IDX) begin
              idx   <= '0;
              state <= ST_KICK;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_KICK: state <= ST_WAIT;
        ST_WAIT: begin
          if (tx_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/udp_row_framer.sv
`timescale 1ns/1ps
module udp_row_framer import urf_pkg::*; #(
  parameter  int          PAY_WORDS = 512,
  parameter  int          ROWS      = 1536,
  parameter  int          CNT_W     = 12,
  parameter  logic [47:0] SRC_MAC   = 48'h1111_1111_1111,
  parameter  logic [47:0] DST_MAC   = 48'hFFFF_FFFF_FFFF,
  parameter  logic [31:0] SRC_IP    = 32'hC0A8_01CC,
  parameter  logic [31:0] DST_IP    = 32'hFFFF_FFFF,
  parameter  logic [15:0] SRC_PORT  = 16'd6000,
  parameter  logic [15:0] DST_PORT  = 16'd6000,
  parameter  logic [7:0]  TTL       = 8'h40,
  localparam int          ADDR_W    = $clog2(HDR_WORDS + PAY_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_idle,
  input  logic              img_restart,
  input  logic [CNT_W-1:0]  fifo_level,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [15:0]       pix_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              tx_start,
  input  logic              tx_done
);
  localparam int RW = $clog2(ROWS);

  urf_state_e        state;
  logic [ADDR_W-1:0] idx;
  logic              frame_go;
  logic              row_adv;
  logic [RW-1:0]     row_cur;
  logic [15:0]       tag_q;
  logic [15:0]       hdr_word;

  urf_seq #(
    .PAY_WORDS(PAY_WORDS),
    .CNT_W    (CNT_W)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .net_idle  (net_idle),
    .fifo_level(fifo_level),
    .pix_valid (pix_valid),
    .wr_ready  (wr_ready),
    .tx_done   (tx_done),
    .state     (state),
    .idx       (idx),
    .frame_go  (frame_go),
    .row_adv   (row_adv)
  );

  urf_row_ctr #(
    .ROWS(ROWS)
  ) i_row (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(row_adv),
    .restart(img_restart),
    .row    (row_cur)
  );

  // The row tag is frozen when a frame launches, so a restart in mid-frame
  // cannot change a word that is already waiting on the bus.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tag_q <= '0;
    else if (frame_go) tag_q <= 16'(row_cur);
  end

  urf_hdr_gen #(
    .PAY_WORDS(PAY_WORDS),
    .SRC_MAC  (SRC_MAC),
    .DST_MAC  (DST_MAC),
    .SRC_IP   (SRC_IP),
    .DST_IP   (DST_IP),
    .SRC_PORT (SRC_PORT),
    .DST_PORT (DST_PORT),
    .TTL      (TTL)
  ) i_hdr (
    .sel    (idx[HSEL_W-1:0]),
    .row_tag(tag_q),
    .word   (hdr_word)
  );

  // The payload goes straight through: pixel valid drives the write, and MAC
  // ready drives the pixel ready.
  assign wr_valid  = (state == ST_HDR) || ((state == ST_PAY) && pix_valid);
  assign pix_ready = (state == ST_PAY) && wr_ready;
  assign wr_addr   = idx;
  assign wr_data   = (state == ST_PAY) ? pix_data : hdr_word;
  assign tx_start  = (state == ST_KICK);
endmodule

// File: rtl/urf_checker.sv
`timescale 1ns/1ps
module urf_checker #(
  parameter int PAY_WORDS = 512,
  parameter int ROWS      = 1536,
  parameter int CNT_W     = 12,
  parameter int ADDR_W    = 10,
  parameter int RW        = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              net_idle,
  input logic              img_restart,
  input logic [CNT_W-1:0]  fifo_level,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              tx_start,
  input logic              row_adv,
  input logic [RW-1:0]     row_cur
);
  localparam int              HDR_N    = 22;
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(HDR_N + PAY_WORDS - 1);
  localparam logic [ADDR_W-1:0] PAY_A0 = ADDR_W'(HDR_N);
  localparam logic [RW-1:0]   TOP_ROW  = RW'(ROWS - 1);

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_valid) && wr_addr == '0) |-> ($past(net_idle) && $past(fifo_level) >= CNT_W'(PAY_WORDS))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr != LAST_A) |=> (wr_addr == $past(wr_addr) + 1'b1)); // R5

  AST_PAY_FOLLOWS_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |-> (wr_valid && wr_ready)); // R5

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R6

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R7

  AST_NO_WR_AT_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !wr_valid); // R7

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_adv && !img_restart && row_cur != TOP_ROW) |=> (row_cur == $past(row_cur) + 1'b1)); // R8

  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_adv && !img_restart && row_cur == TOP_ROW) |=> (row_cur == '0)); // R8

  AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    img_restart |=> (row_cur == '0)); // R9

  AST_PIX_ONLY_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (wr_addr >= PAY_A0)); // R10
endmodule

bind udp_row_framer urf_checker #(
  .PAY_WORDS(PAY_WORDS),
  .ROWS     (ROWS),
  .CNT_W    (CNT_W),
  .ADDR_W   (ADDR_W),
  .RW       (RW)
) i_urf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .net_idle   (net_idle),
  .img_restart(img_restart),
  .fifo_level (fifo_level),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .tx_start   (tx_start),
  .row_adv    (row_adv),
  .row_cur    (row_cur)
);

// File: tb/test_udp_row_framer.sv
`timescale 1ns/1ps
module test_udp_row_framer;
  localparam int PW   = 512;
  localparam int ROWS = 4;
  localparam int CW   = 12;
  localparam int HW   = 22;
  localparam int NW   = HW + PW;
  localparam int AW   = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          net_idle = 1'b0;
  logic          img_restart = 1'b0;
  logic [CW-1:0] fifo_level = '0;
  logic          pix_valid = 1'b0;
  logic          pix_ready;
  logic [15:0]   pix_data = '0;
  logic          wr_valid;
  logic          wr_ready = 1'b1;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic          tx_start;
  logic          tx_done = 1'b0;

  always #4 clk = ~clk;

  udp_row_framer #(.PAY_WORDS(PW), .ROWS(ROWS), .CNT_W(CW)) i_udp_row_framer (
    .clk(clk), .rst_n(rst_n), .net_idle(net_idle), .img_restart(img_restart),
    .fifo_level(fifo_level), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .tx_start(tx_start), .tx_done(tx_done)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pixel source and MAC ready pattern; both change just after the rising edge.
  bit src_on = 0, gap_mode = 0, rdy_mode = 0, fire_q = 0;
  logic [15:0] src_val = 16'h1000;
  always @(posedge clk) begin
    #1;
    if (fire_q) src_val = src_val + 16'd1;
    if (!(pix_valid && !fire_q))
      pix_valid = src_on && (!gap_mode || (cyc % 3) != 0);
    pix_data = src_val;
    wr_ready = !rdy_mode || (cyc % 4) != 1;
  end

  // Monitor at the falling edge.
  logic [15:0] cap [NW];
  int wcnt = 0, ntx = 0, exp_next = 0, last_cyc = 0, tx_cyc = 0;
  int bad_r5 = 0, bad_r6 = 0, bad_r7 = 0, bad_r10 = 0;
  bit waiting = 0;
  always @(negedge clk) begin
    fire_q = pix_valid && pix_ready;
    if (wr_valid && wr_ready) begin
      if (int'(wr_addr) < NW) cap[wr_addr] = wr_data;
      if (int'(wr_addr) != exp_next) bad_r5++;
      exp_next = int'(wr_addr) + 1;
      wcnt++;
      if (int'(wr_addr) == NW - 1) last_cyc = cyc;
      if (int'(wr_addr) >= HW && !fire_q) bad_r5++;
    end
    if (pix_ready && int'(wr_addr) < HW) bad_r10++;
    if (pix_ready && !wr_ready) bad_r6++;
    if (waiting && wr_valid) bad_r7++;
    if (tx_start) begin
      ntx++;
      tx_cyc = cyc;
      if (wr_valid) bad_r7++;
      waiting = 1;
    end
  end

  function automatic logic [15:0] exp_hdr(input int i);
    case (i)
      0, 1, 2, 15, 16: return 16'hFFFF;
      3, 4, 5:         return 16'h1111;
      6:               return 16'h0008;
      7:               return 16'h0045;
      8:               return 16'h1E04;
      11:              return 16'h1140;
      13:              return 16'hA8C0;
      14:              return 16'hCC01;
      17, 18:          return 16'h7017;
      19:              return 16'h0A04;
      default:         return 16'h0000;
    endcase
  endfunction

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #2;
    chk(!wr_valid && !pix_ready && !tx_start, "R1 outputs low in reset",
        {wr_valid, pix_ready, tx_start}, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(!wr_valid && !tx_start, "R1 idle after reset", {wr_valid, tx_start}, 0);
  endtask

  task automatic t_no_start();
    @(posedge clk); #1;
    src_on = 1; wcnt = 0;
    net_idle = 0; fifo_level = CW'(600);
    repeat (40) @(posedge clk);
    chk(wcnt == 0, "R2 no frame while network busy", wcnt, 0);
    #1 net_idle = 1; fifo_level = CW'(PW - 1);
    repeat (40) @(posedge clk);
    chk(wcnt == 0, "R2 no frame one word short", wcnt, 0);
    #1 net_idle = 0; fifo_level = '0;
  endtask

  task automatic t_frame(input string tag, input int exp_row, input bit gap,
                         input bit rdy, input int lvl, input bit rst_with_done);
    int n = 0;
    int pm = 0;
    logic [15:0] base;
    @(posedge clk); #1;
    gap_mode = gap; rdy_mode = rdy;
    wcnt = 0; ntx = 0; exp_next = 0; waiting = 0;
    bad_r5 = 0; bad_r6 = 0; bad_r7 = 0; bad_r10 = 0;
    for (int i = 0; i < NW; i++) cap[i] = 16'hDEAD;
    base = src_val;
    src_on = 1; fifo_level = CW'(lvl); net_idle = 1;
    while (ntx == 0 && n < 20000) begin
      @(posedge clk);
      n++;
    end
    #1 net_idle = 0;
    repeat (6) @(posedge clk);
    #1;
    chk(ntx == 1, {"R7 one tx_start ", tag}, ntx, 1);
    chk(tx_cyc == last_cyc + 1, {"R7 strobe follows last write ", tag}, tx_cyc - last_cyc, 1);
    chk(bad_r7 == 0, {"R7 no write while waiting ", tag}, bad_r7, 0);
    chk(wcnt == NW, {"R5 write count ", tag}, wcnt, NW);
    for (int i = 0; i < HW - 1; i++)
      chk(cap[i] == exp_hdr(i), {"R3 header word ", tag}, cap[i], exp_hdr(i));
    chk(cap[HW-1] == 16'(exp_row), {"R4 row tag ", tag}, cap[HW-1], exp_row);
    for (int k = 0; k < PW; k++)
      if (cap[HW + k] != base + 16'(k)) pm++;
    chk(pm == 0, {"R5 payload order ", tag}, pm, 0);
    chk(bad_r5 == 0, {"R5 consecutive and paired ", tag}, bad_r5, 0);
    chk(bad_r6 == 0, {"R6 no pixel taken on stall ", tag}, bad_r6, 0);
    chk(bad_r10 == 0, {"R10 pixels held during header ", tag}, bad_r10, 0);
    tx_done = 1; img_restart = rst_with_done;
    @(posedge clk); #1;
    tx_done = 0; img_restart = 0; waiting = 0;
    gap_mode = 0; rdy_mode = 0;
  endtask

  task automatic t_restart_idle();
    @(posedge clk); #1 img_restart = 1;
    @(posedge clk); #1 img_restart = 0;
  endtask

  initial begin
    t_reset();
    t_no_start();
    t_frame("plain r0 level exact", 0, 0, 0, PW, 0);
    t_frame("pixel gaps r1", 1, 1, 0, 600, 0);
    t_frame("mac stalls r2", 2, 0, 1, 600, 0);
    t_frame("both stalls r3", 3, 1, 1, 600, 0);
    t_frame("R8 wrap to r0", 0, 0, 0, 600, 0);
    t_frame("r1 before restart", 1, 0, 0, 600, 0);
    t_restart_idle();
    t_frame("R9 after idle restart", 0, 0, 0, 600, 1);
    t_frame("R9 restart beats done", 0, 1, 1, 600, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule